// File: doc/BRIEF.md
# Chained Serializer Diagnostic Reader

This block is an SPI master that reads a chain of industrial input serializers in one transaction. Each chip in the chain supplies eight input bits. In long mode each chip also supplies a status byte. That byte carries a 5-bit checksum of the input byte, an overtemperature flag, an undervoltage alarm and an undervoltage warning. The block clocks in the whole frame and splits it into per-chip words. For each chip it checks the checksum and decodes the flags. It then presents a flat input bitmap together with per-chip error flags.

A chip that is faulting has its eight bits forced to zero. Healthy chips in the same chain are still read normally. An external fault pin can also mark a chip as faulting. A parameter selects whether there is one fault pin per chip or one pin shared by the whole chain. An ignore-undervoltage input suppresses both undervoltage diagnostics and the fault pin. This suits chains that are powered in a way that makes them report undervoltage all the time.

Top module: `daisy_diag_reader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, done is 0 and every data and flag output is 0.
- R2: A frame started in long mode (long_mode=1) has exactly 16 sclk rising edges per chip while cs_n is low. In short mode it has exactly 8 per chip. sclk idles low, and miso is sampled on each rising edge, most significant bit first.
- R3: Bytes are numbered from 0 in order of arrival. In long mode chip i's input byte is byte 2i and its status byte is byte 2i+1. In short mode chip i's input byte is byte i. Output bit in_bits[k] is bit k%8 of chip k/8's input byte.
- R4: In long mode crc_err[i] is 1 when status[7:3] differs from the CRC-5 of the input byte. That CRC uses the polynomial x^5+x^4+x^2+1, starts from zero and processes the byte MSB first.
- R5: In long mode status bit 1 = 1 sets over_temp[i] and makes the chip faulting.
- R6: In long mode status bit 2 = 0 sets uv_alarm[i] and makes the chip faulting, unless ignore_uv is 1.
- R7: In long mode status bit 0 = 0 sets uv_warn[i], unless ignore_uv is 1. A warning never makes a chip faulting.
- R8: A high fault pin makes the chip faulting unless ignore_uv is 1. With FAULT_PER_CHIP=1 chip i uses fault_pin[i]. With FAULT_PER_CHIP=0 every chip uses fault_pin[0]. In short mode the fault pin is the only diagnostic, and crc_err, over_temp, uv_alarm and uv_warn read 0.
- R9: A faulting chip's eight in_bits read 0. A non-faulting chip's bits equal its input byte, whatever the state of the other chips.
- R10: done is a one-cycle pulse per frame. The data and flag outputs change only in the cycle done is high and hold otherwise, even when the fault pins change.
- R11: A start pulse while a frame is in progress is ignored. Neither the frame length nor its result changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame when idle |
| long_mode | input | 1 | 1: input plus status byte per chip; 0: input byte only |
| ignore_uv | input | 1 | Suppress undervoltage diagnostics and the fault pin |
| fault_pin | input | FAULT_PER_CHIP ? NCHIPS : 1 | External fault indications |
| miso | input | 1 | Serial data from the chain |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, low during a frame |
| in_bits | output | 8*NCHIPS | Input bitmap, zeroed for faulting chips |
| chip_fault | output | NCHIPS | Per-chip faulting indication |
| crc_err | output | NCHIPS | Per-chip checksum mismatch |
| over_temp | output | NCHIPS | Per-chip overtemperature |
| uv_alarm | output | NCHIPS | Per-chip undervoltage alarm |
| uv_warn | output | NCHIPS | Per-chip undervoltage warning |
| done | output | 1 | One-cycle pulse when results are updated |

## Verification
All results of a frame are registered on one clock edge. That edge comes one cycle after the final falling sclk edge, the same edge that raises cs_n. They become visible together with the done pulse. The bench therefore waits on the falling clock edge until it sees done high and compares every output in that same half-cycle. It then checks one cycle later that done has dropped. The fault pins are sampled on the result edge, so the bench holds them and ignore_uv steady from start until done. For the hold checks it changes them only after done, then samples again several cycles later, before any new start.

// File: rtl/daisy_diag_pkg.sv
package daisy_diag_pkg;

   typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_t;

   // 5-bit checksum, polynomial x^5+x^4+x^2+1, zero seed, MSB first
   function automatic logic [4:0] crc5_of(input logic [7:0] d);
      logic [4:0] c;
      logic       fb;
      c = 5'd0;
      for (int b = 7; b >= 0; b--) begin
         fb = c[4] ^ d[b];
         c  = {c[3:0], 1'b0} ^ (fb ? 5'b10101 : 5'b00000);
      end
      return c;
   endfunction

endpackage

// File: rtl/daisy_diag_seq.sv
module daisy_diag_seq
   import daisy_diag_pkg::*;
#(
   parameter int FRAME_W = 64,
   parameter int CLKDIV  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               long_mode,
   input  logic               miso,
   output logic               sclk,
   output logic               cs_n,
   output logic               long_q,
   output logic               frame_end,
   output logic [FRAME_W-1:0] frame
);
   localparam int BW = $clog2(FRAME_W + 1);
   localparam int DW = $clog2(CLKDIV + 1);
   localparam logic [BW-1:0] LEN_LONG  = BW'(FRAME_W);
   localparam logic [BW-1:0] LEN_SHORT = BW'(FRAME_W / 2);
   localparam logic [DW-1:0] DIV_LAST  = DW'(CLKDIV - 1);

   seq_state_t    state;
   logic [DW-1:0] div;
   logic [BW-1:0] nbits;
   logic [BW-1:0] target;

   assign target = long_q ? LEN_LONG : LEN_SHORT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         sclk      <= 1'b0;
         cs_n      <= 1'b1;
         div       <= '0;
         nbits     <= '0;
         long_q    <= 1'b0;
         frame_end <= 1'b0;
         frame     <= '0;
      end else begin
         frame_end <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state  <= SEQ_RUN;
                  cs_n   <= 1'b0;
                  long_q <= long_mode;
                  div    <= '0;
                  nbits  <= '0;
               end
            end
            default: begin
               if (div == DIV_LAST) begin
                  div <= '0;
                  if (!sclk) begin
                     sclk  <= 1'b1;
                     frame <= {frame[FRAME_W-2:0], miso};
                     nbits <= nbits + 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (nbits == target) begin
                        cs_n      <= 1'b1;
                        state     <= SEQ_IDLE;
                        frame_end <= 1'b1;
                     end
                  end
               end else begin
                  div <= div + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/daisy_diag_chip.sv
module daisy_diag_chip
   import daisy_diag_pkg::*;
(
   input  logic       long_mode,
   input  logic       ignore_uv,
   input  logic [7:0] data,
   input  logic [7:0] status,
   input  logic       pin,
   output logic [7:0] bits,
   output logic       fault,
   output logic       crc_bad,
   output logic       hot,
   output logic       uv_a,
   output logic       uv_w
);
   always_comb begin
      crc_bad = long_mode && (status[7:3] != crc5_of(data));
      hot     = long_mode && status[1];
      uv_a    = long_mode && !ignore_uv && !status[2];
      uv_w    = long_mode && !ignore_uv && !status[0];
      fault   = crc_bad || hot || uv_a || (pin && !ignore_uv);
      bits    = fault ? 8'h00 : data;
   end
endmodule

// File: rtl/daisy_diag_reader.sv
module daisy_diag_reader
   import daisy_diag_pkg::*;
#(
   parameter int NCHIPS         = 4,
   parameter int CLKDIV         = 2,
   parameter bit FAULT_PER_CHIP = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   start,
   input  logic                                   long_mode,
   input  logic                                   ignore_uv,
   input  logic [(FAULT_PER_CHIP ? NCHIPS : 1)-1:0] fault_pin,
   input  logic                                   miso,
   output logic                                   sclk,
   output logic                                   cs_n,
   output logic [8*NCHIPS-1:0]                    in_bits,
   output logic [NCHIPS-1:0]                      chip_fault,
   output logic [NCHIPS-1:0]                      crc_err,
   output logic [NCHIPS-1:0]                      over_temp,
   output logic [NCHIPS-1:0]                      uv_alarm,
   output logic [NCHIPS-1:0]                      uv_warn,
   output logic                                   done
);
   localparam int FRAME_W = 16 * NCHIPS;

   if (NCHIPS < 1) begin : g_bad_n
      $error("NCHIPS must be at least 1");
   end
   if (CLKDIV < 1) begin : g_bad_div
      $error("CLKDIV must be at least 1");
   end

   logic               long_q, frame_end;
   logic [FRAME_W-1:0] frame;

   daisy_diag_seq #(.FRAME_W(FRAME_W), .CLKDIV(CLKDIV)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode),
      .miso(miso), .sclk(sclk), .cs_n(cs_n), .long_q(long_q),
      .frame_end(frame_end), .frame(frame)
   );

   logic [8*NCHIPS-1:0] bits_d;
   logic [NCHIPS-1:0]   fault_d, crc_d, hot_d, uva_d, uvw_d;

   for (genvar i = 0; i < NCHIPS; i++) begin : g_chip
      logic [7:0] data_b, stat_b;
      logic       pin_b;
      assign data_b = long_q ? frame[(2*NCHIPS-1-2*i)*8 +: 8]
                             : frame[(NCHIPS-1-i)*8 +: 8];
      assign stat_b = frame[(2*NCHIPS-2-2*i)*8 +: 8];
      if (FAULT_PER_CHIP) begin : g_own_pin
         assign pin_b = fault_pin[i];
      end else begin : g_shared_pin
         assign pin_b = fault_pin[0];
      end
      daisy_diag_chip u_dec (
         .long_mode(long_q), .ignore_uv(ignore_uv), .data(data_b),
         .status(stat_b), .pin(pin_b), .bits(bits_d[8*i +: 8]),
         .fault(fault_d[i]), .crc_bad(crc_d[i]), .hot(hot_d[i]),
         .uv_a(uva_d[i]), .uv_w(uvw_d[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_bits    <= '0;
         chip_fault <= '0;
         crc_err    <= '0;
         over_temp  <= '0;
         uv_alarm   <= '0;
         uv_warn    <= '0;
         done       <= 1'b0;
      end else begin
         done <= frame_end;
         if (frame_end) begin
            in_bits    <= bits_d;
            chip_fault <= fault_d;
            crc_err    <= crc_d;
            over_temp  <= hot_d;
            uv_alarm   <= uva_d;
            uv_warn    <= uvw_d;
         end
      end
   end
endmodule

// File: rtl/daisy_diag_chk.sv
module daisy_diag_chk #(
   parameter int NCHIPS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sclk,
   input logic                cs_n,
   input logic                done,
   input logic [8*NCHIPS-1:0] in_bits,
   input logic [NCHIPS-1:0]   chip_fault,
   input logic [NCHIPS-1:0]   crc_err
);
   assert_idle_clock_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);
   assert_select_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !sclk);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);
   assert_hold_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(in_bits) && $stable(chip_fault)));
   assert_crc_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((crc_err & ~chip_fault) == '0));
   for (genvar i = 0; i < NCHIPS; i++) begin : g_a
      assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
         chip_fault[i] |-> (in_bits[8*i +: 8] == 8'h00));
   end
endmodule

bind daisy_diag_reader daisy_diag_chk #(.NCHIPS(NCHIPS)) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .done(done),
   .in_bits(in_bits), .chip_fault(chip_fault), .crc_err(crc_err)
);

// File: tb/sim_daisy_diag_reader.sv
`timescale 1ns/1ps
module sim_daisy_diag_reader;
   localparam int N = 4;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, long_mode = 1'b0, ignore_uv = 1'b0;
   logic [N-1:0] fault_pin = '0;
   logic miso = 1'b0;
   logic sclk, cs_n, done;
   logic [8*N-1:0] in_bits;
   logic [N-1:0] chip_fault, crc_err, over_temp, uv_alarm, uv_warn;

   always #2.5 clk = ~clk;

   daisy_diag_reader #(.NCHIPS(N), .CLKDIV(2), .FAULT_PER_CHIP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode),
      .ignore_uv(ignore_uv), .fault_pin(fault_pin), .miso(miso), .sclk(sclk),
      .cs_n(cs_n), .in_bits(in_bits), .chip_fault(chip_fault), .crc_err(crc_err),
      .over_temp(over_temp), .uv_alarm(uv_alarm), .uv_warn(uv_warn), .done(done)
   );

   int n_chk = 0, n_bad = 0, rises = 0;
   logic [63:0] tx = '0, txsh = '0;

   // chain model: shifts out MSB first, changes on falling sclk
   always @(negedge cs_n) begin txsh = tx; miso = txsh[63]; end
   always @(negedge sclk) begin txsh = txsh << 1; miso = txsh[63]; end
   always @(posedge sclk) if (!cs_n) rises++;

   function automatic logic [4:0] ref_crc(input logic [7:0] d);
      logic [4:0] c = 5'd0;
      for (int b = 7; b >= 0; b--) begin
         logic fb = c[4] ^ d[b];
         c = {c[3:0], 1'b0} ^ (fb ? 5'b10101 : 5'b00000);
      end
      return c;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // [53] long, [52] ignore, [51:48] pins, [47:16] data (chip i at 16+8i),
   // [15:0] flags (chip i at 4i: bit3 bad crc, bit2 hot, bit1 uv alarm, bit0 uv warn)
   localparam int NV = 7;
   localparam logic [53:0] VEC [NV] = '{
      {1'b1, 1'b0, 4'b0000, 32'hFF003CA5, 16'h0000},
      {1'b1, 1'b0, 4'b0000, 32'h5A0F11C4, 16'h0480},
      {1'b1, 1'b0, 4'b0000, 32'h99887766, 16'h1002},
      {1'b1, 1'b1, 4'b0101, 32'h99887766, 16'h1002},
      {1'b0, 1'b0, 4'b1000, 32'h78563412, 16'hFFFF},
      {1'b1, 1'b0, 4'b0010, 32'h01C37E81, 16'h0000},
      {1'b0, 1'b1, 4'b1111, 32'hDEADBEEF, 16'h0000}
   };

   task automatic build(input logic [53:0] v);
      tx = '0;
      for (int i = 0; i < N; i++) begin
         logic [7:0] d = v[16+8*i +: 8];
         logic [3:0] f = v[4*i +: 4];
         logic [7:0] s = {ref_crc(d) ^ (f[3] ? 5'h01 : 5'h00), ~f[1], f[2], ~f[0]};
         if (v[53]) begin
            tx[63-16*i -: 8] = d;
            tx[55-16*i -: 8] = s;
         end else begin
            tx[63-8*i -: 8] = d;
         end
      end
   endtask

   task automatic wait_done();
      while (done !== 1'b1) @(negedge clk);
   endtask

   task automatic run(input logic [53:0] v);
      build(v);
      @(negedge clk);
      long_mode = v[53]; ignore_uv = v[52]; fault_pin = v[51:48];
      rises = 0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_done();
   endtask

   task automatic expect_vec(input logic [53:0] v);
      logic [8*N-1:0] eb;
      logic [N-1:0] ef, ec, eo, ea, ew;
      for (int i = 0; i < N; i++) begin
         logic [3:0] f = v[4*i +: 4];
         ec[i] = v[53] & f[3];
         eo[i] = v[53] & f[2];
         ea[i] = v[53] & ~v[52] & f[1];
         ew[i] = v[53] & ~v[52] & f[0];
         ef[i] = ec[i] | eo[i] | ea[i] | (v[48+i] & ~v[52]);
         eb[8*i +: 8] = ef[i] ? 8'h00 : v[16+8*i +: 8];
      end
      chk("R2 sclk rising edges", 64'(rises), v[53] ? 64'(16*N) : 64'(8*N));
      chk("R3/R9 in_bits", 64'(in_bits), 64'(eb));
      chk("R8 chip_fault", 64'(chip_fault), 64'(ef));
      chk("R4 crc_err", 64'(crc_err), 64'(ec));
      chk("R5 over_temp", 64'(over_temp), 64'(eo));
      chk("R6 uv_alarm", 64'(uv_alarm), 64'(ea));
      chk("R7 uv_warn", 64'(uv_warn), 64'(ew));
      @(negedge clk);
      chk("R10 done one cycle", 64'(done), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", 64'(cs_n), 64'd1);
      chk("R1 sclk", 64'(sclk), 64'd0);
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 outputs", 64'({in_bits, chip_fault, crc_err}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         run(VEC[k]);
         expect_vec(VEC[k]);
      end

      // R10: outputs hold while idle although pins and mode change
      fault_pin = 4'b1111; ignore_uv = 1'b0; long_mode = 1'b1;
      repeat (10) @(negedge clk);
      chk("R10 hold in_bits", 64'(in_bits), 64'hDEADBEEF);
      chk("R10 hold chip_fault", 64'(chip_fault), 64'd0);

      // R11: second start mid-frame (with other mode) is ignored
      build(VEC[0]);
      @(negedge clk);
      long_mode = 1'b1; ignore_uv = 1'b0; fault_pin = 4'b0000;
      rises = 0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      long_mode = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      long_mode = 1'b1;
      wait_done();
      chk("R11 frame length kept", 64'(rises), 64'(16*N));
      chk("R11 result intact", 64'(in_bits), 64'hFF003CA5);
      @(negedge clk);
      chk("R11 single done", 64'(done), 64'd0);
      repeat (30) @(negedge clk);
      chk("R11 no second frame", 64'({cs_n, done}), 64'b10);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule